// File: doc/BRIEF.md
# Tag Access Permission Controller

This block is the access-control part of a contactless memory tag. For every request that reaches it (a login, a word write, a password change or a protected read), it decides whether the tag may go ahead. It answers with an acknowledge or a refusal, plus a grant strobe that lets the memory and serial logic carry out the operation. The memory array and the radio links sit outside the block. The block sees the stored password, protection word and control word as plain input buses, and it tells the outside world nothing about the password except whether a presented value matched.

The controller keeps a login flag and an active copy of the configuration. The active copy holds the read window shown at power-up, the password-check enable, the read-after-write option, the read-protected range and the write-inhibited range. That copy is refreshed only by a restart event, which is either the power-on initialisation or the reset command. A freshly written protection or control word therefore changes nothing until the next restart. A protection word whose write-inhibited range covers its own address can never be changed again.

Each request is held for one clock with `req_valid_i`. The verdict appears on the registered outputs in the following cycle.

Top module: `tag_access_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no other event, `rsp_valid_o`, `rsp_ack_o`, `grant_o`, `logged_in_o`, `raw_en_o`, `first_rd_o` and `last_rd_o` are all zero.
- R2: One cycle after `reload_i` is high, the active configuration is taken from the stored words, and the login flag is cleared. From the control word, bits 7:0 give `first_rd_o`, bits 15:8 give `last_rd_o`, bit 16 is the password-check enable and bit 17 drives `raw_en_o`. From the protection word, bits 7:0 and 15:8 bound the read-protected range, and bits 23:16 and 31:24 bound the write-inhibited range. Every bound is inclusive, and a range whose lower bound is above its upper bound is empty.
- R3: A change on `nv_ctrl_i` or `nv_prot_i` without `reload_i` changes neither the outputs nor later verdicts.
- R4: A request sampled with `req_valid_i` high gives `rsp_valid_o` high for exactly the next cycle, with `rsp_ack_o` at 1 for acknowledge and 0 for refusal. With no request, `rsp_valid_o` is low.
- R5: Op code 0 is login. It is acknowledged and sets `logged_in_o` when `req_pwd_i` equals `nv_pwd_i` and the parity is good. Otherwise it is refused and `logged_in_o` becomes 0.
- R6: Address 0 is refused for both word write (op 1) and read (op 3).
- R7: A word write to address 1 or 2 is acknowledged only when the tag is logged in and the address is outside the write-inhibited range.
- R8: A word write to addresses 3 to 31 is refused when the address is write-inhibited. Otherwise it is acknowledged when password check is off, or when password check is on and the tag is logged in.
- R9: A read (op 3) of addresses 1 to 33 is acknowledged unless the address is read-protected and the tag is not logged in. This holds whatever the password-check bit is. Addresses above 33 are refused.
- R10: A word write to address 32 or above is refused.
- R11: Every request needs `parity_ok_i` high. Word writes and password changes also need `power_ok_i` high. A request missing either is refused.
- R12: Password change (op 2) is acknowledged only when `req_pwd_i` equals `nv_pwd_i`. Login is not needed for it.
- R13: `grant_o` is high exactly when an acknowledge is given for op 1, 2 or 3, and never for a login.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload_i | input | 1 | Restart event (power-on init or reset command) |
| nv_pwd_i | input | 32 | Stored password |
| nv_prot_i | input | 32 | Stored protection word |
| nv_ctrl_i | input | 32 | Stored control word |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 0 login, 1 word write, 2 password change, 3 read |
| req_addr_i | input | 6 | Word address of the request |
| req_pwd_i | input | 32 | Presented password (login, password change) |
| parity_ok_i | input | 1 | Received frame had correct parity |
| power_ok_i | input | 1 | Field supply sufficient for programming |
| rsp_valid_o | output | 1 | Verdict valid |
| rsp_ack_o | output | 1 | 1 acknowledge, 0 refusal |
| grant_o | output | 1 | Memory operation may proceed |
| logged_in_o | output | 1 | Login state |
| first_rd_o | output | 8 | Active first word of the default read window |
| last_rd_o | output | 8 | Active last word of the default read window |
| raw_en_o | output | 1 | Active read-after-write option |

## Verification
The bench targets the places where the permission layers overlap.

- Configuration words are reachable only after login, and a write-inhibited configuration word stays refused even then. A design that checked the inhibit range only for user words would let a locked configuration word be rewritten.
- A read-protected word is refused before login and granted after it, even with password check off. A design that tied read protection to the check bit would leak protected words.
- The bench alters the stored protection word without a restart and expects the old ranges to stay in force. An implementation that decoded the live inputs would change behaviour at once.
- A failed login after a good one must drop the login flag, and a restart must clear it.
- The bench probes the parity and power qualifiers, the read-only addresses 32 and 33, and address 0. These catch any path that grants without all conditions.

// File: rtl/tag_access_pkg.sv
package tag_access_pkg;

    typedef enum logic [1:0] {
        OP_LOGIN = 2'd0,
        OP_WRITE = 2'd1,
        OP_PWCHG = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    localparam int FIELD_W = 8;

    // active configuration, refreshed only on restart
    typedef struct packed {
        logic [FIELD_W-1:0] rd_first;
        logic [FIELD_W-1:0] rd_last;
        logic [FIELD_W-1:0] rp_first;
        logic [FIELD_W-1:0] rp_last;
        logic [FIELD_W-1:0] wi_first;
        logic [FIELD_W-1:0] wi_last;
        logic               pw_check;
        logic               raw_en;
    } cfg_t;

endpackage

// File: rtl/tag_range_match.sv
module tag_range_match #(
    parameter int AW = 6,
    parameter int FW = 8
) (
    input  logic [AW-1:0] addr_i,
    input  logic [FW-1:0] lo_i,
    input  logic [FW-1:0] hi_i,
    output logic          hit_o
);
    localparam int CW = (AW > FW) ? AW : FW;

    logic [CW-1:0] a_ext, lo_ext, hi_ext;

    always_comb begin
        a_ext  = CW'(addr_i);
        lo_ext = CW'(lo_i);
        hi_ext = CW'(hi_i);
        hit_o  = (a_ext >= lo_ext) && (a_ext <= hi_ext);
    end
endmodule

// File: rtl/tag_pwd_cmp.sv
module tag_pwd_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] given_i,
    input  logic [W-1:0] stored_i,
    output logic         match_o
);
    logic [W-1:0] diff;

    always_comb begin
        diff    = given_i ^ stored_i;
        match_o = (diff == '0);
    end
endmodule

// File: rtl/tag_access_rules.sv
module tag_access_rules
    import tag_access_pkg::*;
#(
    parameter int AW        = 6,
    parameter int CFG_LAST  = 2,
    parameter int USER_LAST = 31,
    parameter int ROM_LAST  = 33
) (
    input  op_e           op_i,
    input  logic [AW-1:0] addr_i,
    input  logic          logged_i,
    input  logic          pw_check_i,
    input  logic          rp_hit_i,
    input  logic          wi_hit_i,
    input  logic          pwd_eq_i,
    input  logic          parity_ok_i,
    input  logic          power_ok_i,
    output logic          ack_o,
    output logic          grant_o
);
    localparam int CW = (AW > 7) ? AW : 7;

    logic [CW-1:0] a;
    logic          program_ok;
    logic          permit;

    always_comb begin
        a          = CW'(addr_i);
        program_ok = parity_ok_i && power_ok_i;
        permit     = 1'b0;
        ack_o      = 1'b0;
        unique case (op_i)
            OP_LOGIN: ack_o = parity_ok_i && pwd_eq_i;
            OP_WRITE: begin
                if (a == '0 || a > CW'(USER_LAST)) begin
                    permit = 1'b0;
                end else if (a <= CW'(CFG_LAST)) begin
                    permit = logged_i && !wi_hit_i;
                end else begin
                    permit = !wi_hit_i && (!pw_check_i || logged_i);
                end
                ack_o = permit && program_ok;
            end
            OP_PWCHG: ack_o = pwd_eq_i && program_ok;
            OP_READ: begin
                permit = (a != '0) && (a <= CW'(ROM_LAST)) && (!rp_hit_i || logged_i);
                ack_o  = permit && parity_ok_i;
            end
            default: ack_o = 1'b0;
        endcase
        grant_o = ack_o && (op_i != OP_LOGIN);
    end
endmodule

// File: rtl/tag_access_ctrl.sv
module tag_access_ctrl
    import tag_access_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 6,
    parameter int FW        = FIELD_W,
    parameter int CFG_LAST  = 2,
    parameter int USER_LAST = 31,
    parameter int ROM_LAST  = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload_i,
    input  logic [DW-1:0] nv_pwd_i,
    input  logic [DW-1:0] nv_prot_i,
    input  logic [DW-1:0] nv_ctrl_i,
    input  logic          req_valid_i,
    input  logic [1:0]    req_op_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_pwd_i,
    input  logic          parity_ok_i,
    input  logic          power_ok_i,
    output logic          rsp_valid_o,
    output logic          rsp_ack_o,
    output logic          grant_o,
    output logic          logged_in_o,
    output logic [FW-1:0] first_rd_o,
    output logic [FW-1:0] last_rd_o,
    output logic          raw_en_o
);
    localparam int PWCHK_BIT = 2 * FW;
    localparam int RAW_BIT   = 2 * FW + 1;
    localparam int NRANGE    = 2;

    typedef struct packed {
        cfg_t cfg;
        logic logged;
        logic rsp_v;
        logic rsp_ack;
        logic grant;
    } st_t;

    st_t st_d, st_q;

    op_e           op;
    logic [FW-1:0] lo_b [NRANGE];
    logic [FW-1:0] hi_b [NRANGE];
    logic [NRANGE-1:0] hit;
    logic          pwd_eq, ack, grant;

    assign op = op_e'(req_op_i);

    always_comb begin
        lo_b[0] = st_q.cfg.rp_first;
        hi_b[0] = st_q.cfg.rp_last;
        lo_b[1] = st_q.cfg.wi_first;
        hi_b[1] = st_q.cfg.wi_last;
    end

    // index 0: read-protected range, index 1: write-inhibited range
    for (genvar g = 0; g < NRANGE; g++) begin : g_range
        tag_range_match #(.AW(AW), .FW(FW)) u_rng (
            .addr_i (req_addr_i),
            .lo_i   (lo_b[g]),
            .hi_i   (hi_b[g]),
            .hit_o  (hit[g])
        );
    end

    tag_pwd_cmp #(.W(DW)) u_pwd (
        .given_i  (req_pwd_i),
        .stored_i (nv_pwd_i),
        .match_o  (pwd_eq)
    );

    tag_access_rules #(
        .AW(AW), .CFG_LAST(CFG_LAST), .USER_LAST(USER_LAST), .ROM_LAST(ROM_LAST)
    ) u_rules (
        .op_i        (op),
        .addr_i      (req_addr_i),
        .logged_i    (st_q.logged),
        .pw_check_i  (st_q.cfg.pw_check),
        .rp_hit_i    (hit[0]),
        .wi_hit_i    (hit[1]),
        .pwd_eq_i    (pwd_eq),
        .parity_ok_i (parity_ok_i),
        .power_ok_i  (power_ok_i),
        .ack_o       (ack),
        .grant_o     (grant)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rsp_v   = 1'b0;
        st_d.rsp_ack = 1'b0;
        st_d.grant   = 1'b0;
        if (reload_i) begin
            st_d.cfg.rd_first = nv_ctrl_i[FW-1:0];
            st_d.cfg.rd_last  = nv_ctrl_i[2*FW-1:FW];
            st_d.cfg.pw_check = nv_ctrl_i[PWCHK_BIT];
            st_d.cfg.raw_en   = nv_ctrl_i[RAW_BIT];
            st_d.cfg.rp_first = nv_prot_i[FW-1:0];
            st_d.cfg.rp_last  = nv_prot_i[2*FW-1:FW];
            st_d.cfg.wi_first = nv_prot_i[3*FW-1:2*FW];
            st_d.cfg.wi_last  = nv_prot_i[4*FW-1:3*FW];
            st_d.logged       = 1'b0;
        end else if (req_valid_i) begin
            st_d.rsp_v   = 1'b1;
            st_d.rsp_ack = ack;
            st_d.grant   = grant;
            if (op == OP_LOGIN) begin
                st_d.logged = ack;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o = st_q.rsp_v;
    assign rsp_ack_o   = st_q.rsp_ack;
    assign grant_o     = st_q.grant;
    assign logged_in_o = st_q.logged;
    assign first_rd_o  = st_q.cfg.rd_first;
    assign last_rd_o   = st_q.cfg.rd_last;
    assign raw_en_o    = st_q.cfg.raw_en;
endmodule

// File: rtl/tag_access_ctrl_chk.sv
module tag_access_ctrl_chk #(
    parameter int AW = 6,
    parameter int FW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reload_i,
    input logic          req_valid_i,
    input logic [1:0]    req_op_i,
    input logic [AW-1:0] req_addr_i,
    input logic          parity_ok_i,
    input logic          power_ok_i,
    input logic          rsp_valid_o,
    input logic          rsp_ack_o,
    input logic          grant_o,
    input logic          logged_in_o,
    input logic [FW-1:0] first_rd_o,
    input logic [FW-1:0] last_rd_o,
    input logic          raw_en_o
);
    logic new_req;
    assign new_req = req_valid_i && !reload_i;

    AST_CFG_ONLY_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_i |=> ($stable(first_rd_o) && $stable(last_rd_o) && $stable(raw_en_o))) else $error("cfg moved"); // R3

    AST_RELOAD_CLEARS_LOGIN: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> !logged_in_o) else $error("login kept"); // R2

    AST_ONE_CYCLE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        new_req |=> rsp_valid_o) else $error("no verdict"); // R4

    AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !new_req |=> !rsp_valid_o) else $error("spurious verdict"); // R4

    AST_ADDR0_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (new_req && req_op_i[0] && req_addr_i == '0) |=> !rsp_ack_o) else $error("addr0"); // R6

    AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (new_req && req_op_i == 2'd1 && req_addr_i >= AW'(32)) |=> !rsp_ack_o) else $error("rom write"); // R10

    AST_WRITE_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        (new_req && (req_op_i == 2'd1 || req_op_i == 2'd2) && !power_ok_i) |=> !rsp_ack_o) else $error("power"); // R11

    AST_NO_PARITY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (new_req && !parity_ok_i) |=> !rsp_ack_o) else $error("parity"); // R11

    AST_GRANT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> (rsp_ack_o && rsp_valid_o)) else $error("grant"); // R13

    AST_LOGIN_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (new_req && req_op_i == 2'd0) |=> !grant_o) else $error("login grant"); // R13
endmodule

bind tag_access_ctrl tag_access_ctrl_chk #(.AW(AW), .FW(FW)) u_chk (.*);

// File: tb/tag_access_ctrl_tb.sv
module tag_access_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reload_i = 1'b0;
    logic [31:0] nv_pwd_i = 32'hA5C3_0F17;
    logic [31:0] nv_prot_i, nv_ctrl_i;
    logic        req_valid_i = 1'b0;
    logic [1:0]  req_op_i = 2'd0;
    logic [5:0]  req_addr_i = '0;
    logic [31:0] req_pwd_i = '0;
    logic        parity_ok_i = 1'b1;
    logic        power_ok_i = 1'b1;
    logic        rsp_valid_o, rsp_ack_o, grant_o, logged_in_o, raw_en_o;
    logic [7:0]  first_rd_o, last_rd_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tag_access_ctrl u_dut (.*);

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reload(input logic [31:0] ctrl, input logic [31:0] prot);
        @(negedge clk);
        nv_ctrl_i = ctrl;
        nv_prot_i = prot;
        reload_i  = 1'b1;
        @(negedge clk);
        reload_i  = 1'b0;
    endtask

    // drives one request for one cycle, returns at the negedge after the verdict register
    task automatic request(input logic [1:0] op, input logic [5:0] addr, input bit good_pw,
                           input bit par, input bit pwr);
        @(negedge clk);
        req_valid_i = 1'b1;
        req_op_i    = op;
        req_addr_i  = addr;
        req_pwd_i   = good_pw ? nv_pwd_i : ~nv_pwd_i;
        parity_ok_i = par;
        power_ok_i  = pwr;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    // vector: [16:13] requirement number, [12:11] op, [10:5] addr, [4] good pw,
    //         [3] parity, [2] power, [1] expected ack, [0] expected login flag
    localparam int NV = 25;
    localparam logic [16:0] VEC [NV] = '{
        {4'd9,  2'd3, 6'd11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R9 protected read before login
        {4'd9,  2'd3, 6'd13, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R9 unprotected read
        {4'd6,  2'd3, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 password never readable
        {4'd9,  2'd3, 6'd33, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R9 read-only word readable
        {4'd9,  2'd3, 6'd34, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R9 beyond map
        {4'd8,  2'd1, 6'd5,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R8 check on, no login
        {4'd7,  2'd1, 6'd1,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 config word without login
        {4'd5,  2'd0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 wrong password
        {4'd11, 2'd0, 6'd0,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R11 bad parity login
        {4'd5,  2'd0, 6'd0,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R5 good login
        {4'd9,  2'd3, 6'd11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R9 protected read after login
        {4'd7,  2'd1, 6'd1,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R7 config word logged in
        {4'd7,  2'd1, 6'd2,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R7 inhibited config word
        {4'd8,  2'd1, 6'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R8 inhibited user word
        {4'd8,  2'd1, 6'd5,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R8 logged in write
        {4'd11, 2'd1, 6'd5,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R11 no power
        {4'd6,  2'd1, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R6 password by word write
        {4'd10, 2'd1, 6'd32, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R10 read-only word
        {4'd10, 2'd1, 6'd33, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R10 read-only word
        {4'd12, 2'd2, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R12 wrong current password
        {4'd12, 2'd2, 6'd0,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R12 good password change
        {4'd11, 2'd2, 6'd0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R11 change without power
        {4'd8,  2'd1, 6'd31, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R8 last user word
        {4'd5,  2'd0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 failed login drops flag
        {4'd8,  2'd1, 6'd31, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}  // R8 login needed again
    };

    localparam logic [31:0] CTRL_A = 32'h0003_0905; // first 5, last 9, check on, raw on
    localparam logic [31:0] PROT_A = 32'h0402_0C0A; // read-protect 10..12, inhibit 2..4

    initial begin
        nv_ctrl_i = CTRL_A;
        nv_prot_i = PROT_A;
        #1;
        check("R1", "rsp_valid in reset", {31'd0, rsp_valid_o}, 32'd0);
        check("R1", "login in reset", {31'd0, logged_in_o}, 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "first_rd after reset", {24'd0, first_rd_o}, 32'd0);
        check("R1", "raw_en after reset", {31'd0, raw_en_o}, 32'd0);

        reload(CTRL_A, PROT_A);
        check("R2", "first_rd", {24'd0, first_rd_o}, 32'd5);
        check("R2", "last_rd", {24'd0, last_rd_o}, 32'd9);
        check("R2", "raw_en", {31'd0, raw_en_o}, 32'd1);
        check("R4", "idle rsp_valid", {31'd0, rsp_valid_o}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [16:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d", v[16:13]);
            request(v[12:11], v[10:5], v[4], v[3], v[2]);
            check("R4", "rsp_valid", {31'd0, rsp_valid_o}, 32'd1);
            check(tag, $sformatf("ack vec %0d", i), {31'd0, rsp_ack_o}, {31'd0, v[1]});
            check("R13", $sformatf("grant vec %0d", i), {31'd0, grant_o},
                  {31'd0, v[1] && (v[12:11] != 2'd0)});
            check(tag, $sformatf("login vec %0d", i), {31'd0, logged_in_o}, {31'd0, v[0]});
            @(negedge clk);
            check("R4", "verdict lasts one cycle", {31'd0, rsp_valid_o}, 32'd0);
        end

        // R3: stored words change without restart; old ranges stay in force
        @(negedge clk);
        nv_ctrl_i = 32'h0000_2120;
        nv_prot_i = 32'h0000_0D0D;
        repeat (2) @(negedge clk);
        check("R3", "first_rd unchanged", {24'd0, first_rd_o}, 32'd5);
        request(2'd3, 6'd13, 1'b0, 1'b1, 1'b1);
        check("R3", "read 13 still free", {31'd0, rsp_ack_o}, 32'd1);

        // R2: restart applies new words and clears login
        request(2'd0, 6'd0, 1'b1, 1'b1, 1'b1);
        check("R5", "login before restart", {31'd0, logged_in_o}, 32'd1);
        reload(32'h0000_2120, 32'h0000_0D0D);
        check("R2", "login cleared", {31'd0, logged_in_o}, 32'd0);
        check("R2", "new first_rd", {24'd0, first_rd_o}, 32'h20);
        check("R2", "new last_rd", {24'd0, last_rd_o}, 32'h21);
        check("R2", "raw off", {31'd0, raw_en_o}, 32'd0);
        request(2'd3, 6'd13, 1'b0, 1'b1, 1'b1);
        check("R9", "read 13 now protected", {31'd0, rsp_ack_o}, 32'd0);

        // R8: password check off, free user write; R7 config still needs login
        request(2'd1, 6'd5, 1'b0, 1'b1, 1'b1);
        check("R8", "free write, check off", {31'd0, rsp_ack_o}, 32'd1);
        check("R13", "free write grant", {31'd0, grant_o}, 32'd1);
        request(2'd1, 6'd2, 1'b0, 1'b1, 1'b1);
        check("R7", "config write, check off", {31'd0, rsp_ack_o}, 32'd0);
        request(2'd3, 6'd5, 1'b0, 1'b0, 1'b1);
        check("R11", "read with bad parity", {31'd0, rsp_ack_o}, 32'd0);

        // R7: self-inhibited protection word stays locked even after login
        reload(32'h0001_0000, 32'h0101_0000);
        request(2'd0, 6'd0, 1'b1, 1'b1, 1'b1);
        request(2'd1, 6'd1, 1'b0, 1'b1, 1'b1);
        check("R7", "locked protection word", {31'd0, rsp_ack_o}, 32'd0);
        request(2'd1, 6'd2, 1'b0, 1'b1, 1'b1);
        check("R7", "control word writable", {31'd0, rsp_ack_o}, 32'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule